// File: doc/BRIEF.md
# Bus-Matching FIFO Read-Side Unpacker

This block sits between the 36-bit storage array of a FIFO and its narrow read port. The storage holds long words, and the read port can be set to return each long word whole, as two 18-bit halves, or as four 9-bit bytes. The block keeps the current long word in a holding register and tracks which slice of it is next. It asks storage for the next long word only once the final slice of the held word has been read.

The port width, the slice order and the flag timing are configuration inputs. They are sampled on every clock edge while reset is held low and are then frozen until the next reset. In standard timing, `b_ready` means a read may be issued, and the slice appears on `rd_data` after the edge that reads it. In fall-through timing, `b_ready` means that `rd_data` already carries a valid slice, and the read edge moves on to the next one.

The storage side is show-ahead. `st_data` is the head word whenever `st_empty` is low, and a high `st_pop` at an edge removes that word. Storage may be written on the same edge on which it is popped.

Top module: `fifo_rd_unpacker`

## Requirements
- R1: With width code 0 (long), each read returns the whole 36-bit word on `rd_data[35:0]`, and each read of a held word pops one new word.
- R2: With width code 1 (half) and `cfg_little`=0, a word yields two beats in the order bits [35:18], then [17:0]. Each beat is placed in `rd_data[17:0]`, and the upper bits are zero.
- R3: With width code 1 and `cfg_little`=1, the half order is reversed: [17:0] first, then [35:18].
- R4: With width code 2 (byte) and `cfg_little`=0, a word yields four 9-bit beats in the order [35:27], [26:18], [17:9], [8:0]. Each beat is placed in `rd_data[8:0]`, and the upper bits are zero.
- R5: With width code 2 and `cfg_little`=1, the byte order is [8:0], [17:9], [26:18], [35:27].
- R6: `st_pop` is raised only when storage is not empty and either no word is held or the final slice of the held word is being read. A held word is never replaced before its final slice has been read.
- R7: With `cfg_fwft`=0, `rd_data` changes only on an edge where `rd_en`=1 and `b_ready`=1. A read while `b_ready`=0 changes neither the output nor the storage.
- R8: With `cfg_fwft`=1, `rd_data` shows the current slice as soon as `b_ready` rises, with no read needed, and holds that slice while no read occurs.
- R9: The configuration inputs are sampled only while `rst_n`=0. Changing them after reset has no effect on width, order or timing.
- R10: While `rst_n`=0, `b_ready`=0, `st_pop`=0 and `rd_data`=0.
- R11: Width code 3 behaves as width code 0.
- R12: With `rd_en` held high, a read of a final slice and the pop of the next word happen on the same edge, so `b_ready` stays high with no gap while storage has words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is sampled while it is low |
| cfg_width | input | 2 | Port width code: 0 long, 1 half, 2 byte, 3 same as long |
| cfg_little | input | 1 | 1 = least significant slice first |
| cfg_fwft | input | 1 | 1 = fall-through timing, 0 = standard timing |
| st_empty | input | 1 | Storage holds no word |
| st_data | input | 36 | Head word of storage, valid while `st_empty`=0 |
| st_pop | output | 1 | Remove the head word from storage at this edge |
| rd_en | input | 1 | Read enable of the narrow port |
| rd_data | output | 36 | Read data; narrow beats are right-aligned and zero-extended |
| b_ready | output | 1 | Data available (standard) or output valid (fall-through) |

## Verification
Every combination of width, order and timing is driven with two different long words queued back to back. The beats then show whether the slices come out in the right order and right-aligned, and the pop count taken before and after the final slice shows whether storage is asked too early. Reads while empty and idle gaps in standard timing separate a registered output from a flow-through one. A hold-off in fall-through timing shows that data falls through without a read. Changing the configuration after reset shows whether it is ignored, and a continuous read stream shows whether refills leave gaps.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

   typedef enum logic [1:0] {
      BW_LONG = 2'd0,
      BW_HALF = 2'd1,
      BW_BYTE = 2'd2,
      BW_RSVD = 2'd3
   } bus_width_e;

   typedef struct packed {
      bus_width_e width;
      logic       little;
      logic       fwft;
   } port_cfg_t;

endpackage

// File: rtl/unpack_cfg_reg.sv
module unpack_cfg_reg
   import unpack_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] width_in,
   input  logic       little_in,
   input  logic       fwft_in,
   output port_cfg_t  cfg_o
);

   port_cfg_t cfg_q;

   // capture while reset is held, freeze afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q.width  <= (width_in == 2'd3) ? BW_LONG : bus_width_e'(width_in);
         cfg_q.little <= little_in;
         cfg_q.fwft   <= fwft_in;
      end
   end

   assign cfg_o = cfg_q;

endmodule

// File: rtl/unpack_slicer.sv
module unpack_slicer
   import unpack_pkg::*;
#(
   parameter int WORD_W = 36,
   parameter int LANES  = 4,
   localparam int IDX_W  = $clog2(LANES),
   localparam int LANE_W = WORD_W / LANES,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic [WORD_W-1:0] word_i,
   input  bus_width_e        width_i,
   input  logic              little_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [WORD_W-1:0] slice_o
);

   logic [LANE_W-1:0] lane [LANES];
   logic [HALF_W-1:0] half [2];
   logic [IDX_W-1:0]  lane_pos;
   logic              half_pos;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word_i[g*LANE_W +: LANE_W];
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half[h] = word_i[h*HALF_W +: HALF_W];
   end

   assign lane_pos = little_i ? idx_i : (IDX_W'(LANES - 1) - idx_i);
   assign half_pos = little_i ? idx_i[0] : ~idx_i[0];

   always_comb begin
      slice_o = '0;
      case (width_i)
         BW_HALF: slice_o[HALF_W-1:0] = half[half_pos];
         BW_BYTE: slice_o[LANE_W-1:0] = lane[lane_pos];
         default: slice_o = word_i;
      endcase
   end

endmodule

// File: rtl/unpack_seq.sv
module unpack_seq
   import unpack_pkg::*;
#(
   parameter int WORD_W = 36,
   parameter int LANES  = 4,
   localparam int IDX_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_width_e        width_i,
   input  logic              st_empty,
   input  logic [WORD_W-1:0] st_data,
   input  logic              rd_en,
   output logic              st_pop,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o,
   output logic [IDX_W-1:0]  idx_o
);

   localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(LANES - 1);
   localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(1);

   logic [WORD_W-1:0] word_q;
   logic              valid_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_idx;
   logic              consume;
   logic              at_last;
   logic              refill;

   always_comb begin
      case (width_i)
         BW_HALF: last_idx = LAST_HALF;
         BW_BYTE: last_idx = LAST_BYTE;
         default: last_idx = '0;
      endcase
   end

   assign consume = rd_en & valid_q;
   assign at_last = (idx_q == last_idx);
   assign refill  = ~st_empty & (~valid_q | (consume & at_last));
   assign st_pop  = rst_n & refill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
         idx_q   <= '0;
      end else begin
         if (consume) begin
            idx_q <= at_last ? '0 : idx_q + 1'b1;
         end
         if (st_pop) begin
            word_q  <= st_data;
            valid_q <= 1'b1;
         end else if (consume && at_last) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign word_o  = word_q;
   assign valid_o = valid_q;
   assign idx_o   = idx_q;

endmodule

// File: rtl/fifo_rd_unpacker.sv
module fifo_rd_unpacker
   import unpack_pkg::*;
#(
   parameter int WORD_W = 36,
   parameter int LANES  = 4,
   localparam int IDX_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_little,
   input  logic              cfg_fwft,
   input  logic              st_empty,
   input  logic [WORD_W-1:0] st_data,
   output logic              st_pop,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              b_ready
);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (WORD_W % LANES != 0) begin : g_bad_word
      $error("WORD_W must split evenly into LANES slices");
   end

   port_cfg_t         cfg_q;
   logic [WORD_W-1:0] cur_word;
   logic              cur_valid;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] slice;
   logic [WORD_W-1:0] dout_q;

   unpack_cfg_reg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .width_in  (cfg_width),
      .little_in (cfg_little),
      .fwft_in   (cfg_fwft),
      .cfg_o     (cfg_q)
   );

   unpack_seq #(.WORD_W(WORD_W), .LANES(LANES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .width_i  (cfg_q.width),
      .st_empty (st_empty),
      .st_data  (st_data),
      .rd_en    (rd_en),
      .st_pop   (st_pop),
      .word_o   (cur_word),
      .valid_o  (cur_valid),
      .idx_o    (idx_q)
   );

   unpack_slicer #(.WORD_W(WORD_W), .LANES(LANES)) u_slice (
      .word_i   (cur_word),
      .width_i  (cfg_q.width),
      .little_i (cfg_q.little),
      .idx_i    (idx_q),
      .slice_o  (slice)
   );

   // standard timing: slice is registered on the read edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q <= '0;
      end else if (rd_en && cur_valid && !cfg_q.fwft) begin
         dout_q <= slice;
      end
   end

   assign rd_data = cfg_q.fwft ? slice : dout_q;
   assign b_ready = cur_valid;

endmodule

// File: rtl/unpack_checker.sv
module unpack_checker #(
   parameter int WORD_W = 36,
   parameter int LANES  = 4,
   localparam int IDX_W = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_empty,
   input logic              st_pop,
   input logic              rd_en,
   input logic              b_ready,
   input logic [WORD_W-1:0] rd_data,
   input logic [IDX_W-1:0]  idx,
   input logic [3:0]        cfg_bits
);

   logic [IDX_W-1:0] last;
   always_comb begin
      case (cfg_bits[3:2])
         2'd1:    last = IDX_W'(1);
         2'd2:    last = IDX_W'(LANES - 1);
         default: last = '0;
      endcase
   end

   // R6: storage is popped only while it holds a word
   p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_pop |-> !st_empty);

   // R6: a held word is not replaced before its final slice is read
   p_no_early_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (b_ready && !(rd_en && idx == last)) |-> !st_pop);

   // R6: slice index moves only on a read of valid data
   p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && b_ready) |=> $stable(idx));

   // R4: slice index stays within the configured count
   p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= last);

   // R7: standard-timing output only changes on a read edge
   p_std_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bits[0] && !(rd_en && b_ready)) |=> $stable(rd_data));

   // R9: configuration frozen after reset
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(cfg_bits));

   // R12: final-slice read with storage non-empty refills on the same edge
   p_refill_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (b_ready && rd_en && idx == last && !st_empty) |-> st_pop);

   // R10: no pop request while reset is held
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         p_reset_quiet_r10: assert (st_pop == 1'b0);
      end
   end

endmodule

bind fifo_rd_unpacker unpack_checker #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .st_empty (st_empty),
   .st_pop   (st_pop),
   .rd_en    (rd_en),
   .b_ready  (b_ready),
   .rd_data  (rd_data),
   .idx      (idx_q),
   .cfg_bits (cfg_q)
);

// File: tb/fifo_rd_unpacker_test.sv
`timescale 1ns/1ps
module fifo_rd_unpacker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_width = 2'd0;
   logic        cfg_little = 1'b0;
   logic        cfg_fwft = 1'b0;
   logic        st_empty;
   logic [35:0] st_data;
   logic        st_pop;
   logic        rd_en = 1'b0;
   logic [35:0] rd_data;
   logic        b_ready;

   int checks = 0;
   int errors = 0;
   int pops = 0;

   // storage model: show-ahead queue
   logic [35:0] q [64];
   int qh = 0;
   int qt = 0;
   assign st_empty = (qh == qt);
   assign st_data  = q[qh & 63];
   always @(posedge clk) begin
      if (st_pop) begin
         qh <= qh + 1;
         pops <= pops + 1;
      end
   end

   always #2.5 clk = ~clk;

   fifo_rd_unpacker uut (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_little(cfg_little),
      .cfg_fwft(cfg_fwft), .st_empty(st_empty), .st_data(st_data), .st_pop(st_pop),
      .rd_en(rd_en), .rd_data(rd_data), .b_ready(b_ready)
   );

   typedef struct packed {
      logic [1:0]  wmode;
      logic        little;
      logic        fwft;
      logic [35:0] w;
   } vec_t;

   localparam vec_t VECS [13] = '{
      '{2'd0, 1'b0, 1'b0, 36'h123456789},
      '{2'd0, 1'b0, 1'b1, 36'hFEDCBA987},
      '{2'd1, 1'b0, 1'b0, 36'hA5A5C3C3F},
      '{2'd1, 1'b0, 1'b1, 36'h0F0F1E1E2},
      '{2'd1, 1'b1, 1'b0, 36'h8BADF00D1},
      '{2'd1, 1'b1, 1'b1, 36'h3C0FFEE42},
      '{2'd2, 1'b0, 1'b0, 36'h123456789},
      '{2'd2, 1'b0, 1'b1, 36'hDEADBEEF5},
      '{2'd2, 1'b1, 1'b0, 36'h987654321},
      '{2'd2, 1'b1, 1'b1, 36'hC001D00D7},
      '{2'd0, 1'b1, 1'b0, 36'h55AA55AA5},
      '{2'd3, 1'b0, 1'b0, 36'h13579BDF0},
      '{2'd3, 1'b1, 1'b1, 36'h2468ACE13}
   };

   function automatic int n_beats(input logic [1:0] m);
      return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
   endfunction

   // expected beat k of word w, computed from the requirement text
   function automatic logic [35:0] exp_beat(input logic [35:0] w, input logic [1:0] m,
                                            input logic lit, input int k);
      int pos;
      if (m == 2'd1) begin
         pos = lit ? k : 1 - k;
         return (w >> (pos * 18)) & 36'h3FFFF;
      end else if (m == 2'd2) begin
         pos = lit ? k : 3 - k;
         return (w >> (pos * 9)) & 36'h1FF;
      end
      return w;
   endfunction

   function automatic string req_of(input logic [1:0] m, input logic lit);
      if (m == 2'd1) return lit ? "R3" : "R2";
      if (m == 2'd2) return lit ? "R5" : "R4";
      if (m == 2'd3) return "R11";
      return "R1";
   endfunction

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic push(input logic [35:0] w);
      q[qt & 63] = w;
      qt = qt + 1;
   endtask

   task automatic do_reset(input logic [1:0] m, input logic lit, input logic ff);
      @(negedge clk);
      rst_n = 1'b0;
      rd_en = 1'b0;
      cfg_width = m;
      cfg_little = lit;
      cfg_fwft = ff;
      qt = qh;
      repeat (3) @(negedge clk);
   endtask

   task automatic read_beat(input logic ff, output logic [35:0] v);
      while (!b_ready) @(negedge clk);
      if (ff) begin
         v = rd_data;
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end else begin
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
         v = rd_data;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [35:0] v;
      logic [35:0] w2;
      int base;

      // R10: reset state with a word already waiting in storage
      do_reset(2'd2, 1'b0, 1'b0);
      push(36'h111222333);
      @(negedge clk);
      chk("R10 b_ready", {35'd0, b_ready}, 36'd0);
      chk("R10 st_pop", {35'd0, st_pop}, 36'd0);
      chk("R10 rd_data", rd_data, 36'd0);

      // R9: change configuration after reset; byte BE standard must persist
      rst_n = 1'b1;
      cfg_width = 2'd0;
      cfg_little = 1'b1;
      cfg_fwft = 1'b1;
      for (int k = 0; k < 4; k++) begin
         read_beat(1'b0, v);
         chk("R9 beat", v, exp_beat(36'h111222333, 2'd2, 1'b0, k));
      end

      // table walk: every width, order, timing
      for (int i = 0; i < 13; i++) begin
         do_reset(VECS[i].wmode, VECS[i].little, VECS[i].fwft);
         rst_n = 1'b1;
         base = pops;
         w2 = {VECS[i].w[17:0], VECS[i].w[35:18]} ^ 36'h0F0F0F0F0;
         push(VECS[i].w);
         push(w2);
         for (int k = 0; k < n_beats(VECS[i].wmode); k++) begin
            read_beat(VECS[i].fwft, v);
            chk(req_of(VECS[i].wmode, VECS[i].little), v,
                exp_beat(VECS[i].w, VECS[i].wmode, VECS[i].little, k));
            if (k == n_beats(VECS[i].wmode) - 2)
               chk("R6 no early pop", 36'(pops - base), 36'd1);
         end
         chk("R6 refill pop", 36'(pops - base), 36'd2);
         for (int k = 0; k < n_beats(VECS[i].wmode); k++) begin
            read_beat(VECS[i].fwft, v);
            chk(req_of(VECS[i].wmode, VECS[i].little), v,
                exp_beat(w2, VECS[i].wmode, VECS[i].little, k));
         end
         @(negedge clk);
         chk("R6 drained", {35'd0, b_ready}, 36'd0);
      end

      // R7: standard timing, reads while empty are ignored, output held
      do_reset(2'd0, 1'b0, 1'b0);
      rst_n = 1'b1;
      push(36'hABCDE0123);
      read_beat(1'b0, v);
      chk("R7 first", v, 36'hABCDE0123);
      base = pops;
      rd_en = 1'b1;
      repeat (2) @(negedge clk);
      rd_en = 1'b0;
      chk("R7 empty read data", rd_data, 36'hABCDE0123);
      chk("R7 empty read pops", 36'(pops - base), 36'd0);
      push(36'h456789ABC);
      repeat (3) @(negedge clk);
      chk("R7 idle hold", rd_data, 36'hABCDE0123);
      chk("R7 ready", {35'd0, b_ready}, 36'd1);
      read_beat(1'b0, v);
      chk("R7 next", v, 36'h456789ABC);

      // R8: fall-through shows data without a read
      do_reset(2'd2, 1'b1, 1'b1);
      rst_n = 1'b1;
      push(36'h9ABCDEF01);
      repeat (3) @(negedge clk);
      chk("R8 ready", {35'd0, b_ready}, 36'd1);
      chk("R8 fall through", rd_data, 36'h9ABCDEF01 & 36'h1FF);
      repeat (2) @(negedge clk);
      chk("R8 hold", rd_data, 36'h9ABCDEF01 & 36'h1FF);

      // R12: continuous reads, long fall-through
      do_reset(2'd0, 1'b0, 1'b1);
      rst_n = 1'b1;
      push(36'h000000001);
      push(36'h000000002);
      push(36'h000000003);
      while (!b_ready) @(negedge clk);
      rd_en = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         chk("R12 stream ready", {35'd0, b_ready}, 36'd1);
         chk("R12 stream data", rd_data, 36'(k));
         @(negedge clk);
      end
      rd_en = 1'b0;
      chk("R12 stream end", {35'd0, b_ready}, 36'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule